// File: doc/BRIEF.md
# Cylinder Burst DMA Engine

This block copies one full disk cylinder from a byte-wide disk stream into physical memory as a single DMA burst. A cylinder is the product of the recording surface count, the sectors per cluster and the sector size. With the default parameters that is 3 × 2 × 1024 = 6144 bytes, and the byte counter is 13 bits wide.

A host sets the engine up through a small word-wide register port. It writes a start address and then a command word, and it polls a status word. Once a start is accepted, the engine raises a bus request and waits for the grant. It then keeps the bus for the whole burst. Each byte taken from the disk stream is written to the next consecutive memory address, and the engine stalls whenever the stream has no byte ready. After the last byte the engine releases the bus, sets a done flag and pulses an interrupt for one cycle.

Top module: `cyl_dma_engine`

## Requirements
- R1: After reset, status reads 0, the address register reads 0, and bus_req, irq and mem_we are all low.
- R2: The register offsets are: 0 for the memory address (read/write), 1 for the command (write-only; reads return 0) and 2 for the status (read-only). Offset 3 reads 0. Status layout: bit 0 busy, bit 1 done, bits 14:2 bytes moved, and the higher bits 0.
- R3: A host write to the status offset has no effect on the status.
- R4: A command write with bit 0 = 1 (start) and bit 1 = 0 (disk to memory), made while idle, sets busy and clears done and the byte count. bus_req goes high in the next cycle. No byte is accepted or written until bus_gnt is high.
- R5: Bytes are written in stream order to consecutive addresses that start at the programmed address. The address advances by 1 for each accepted byte, wraps modulo 2^32, and holds while disk_valid is low. During a stall mem_we is low.
- R6: A transfer moves exactly 6144 bytes. The status count always equals the number of bytes accepted so far.
- R7: bus_req stays high from acceptance until the cycle after the last byte is written. In that cycle it drops.
- R8: In the cycle after the final byte, done = 1, busy = 0, the count reads 6144, and irq is high for exactly one cycle.
- R9: While busy, a start command and a write to the address register are both ignored.
- R10: A command with bit 1 = 1 (memory to disk) is not accepted. Busy, done and bus_req all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| disk_valid | input | 1 | Disk byte available |
| disk_data | input | 8 | Disk byte |
| disk_ready | output | 1 | Engine can take a byte |
| bus_req | output | 1 | Bus request, held for the whole burst |
| bus_gnt | input | 1 | Bus grant |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are the ones where the engine must ignore host traffic while it is busy. One is a restart or an address rewrite arriving while the grant is still pending; another is the same traffic arriving in the middle of a burst. The stimulus holds the grant off and issues both writes. It then issues a second start partway through the burst. Because a wrongly accepted restart would lengthen the burst, the final address pins down that the restart was ignored. The burst is also run with several valid-gap patterns, including one where only one cycle in eight carries a byte and a start address that wraps past 2^32.

// File: rtl/cyl_dma_engine.sv
module cyl_dma_engine #(
  parameter int SURFACES            = 3,
  parameter int SECTORS_PER_CLUSTER = 2,
  parameter int SECTOR_BYTES        = 1024,
  parameter int ADDR_W              = 32,
  parameter int REG_W               = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              disk_valid,
  input  logic [7:0]        disk_data,
  output logic              disk_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              irq
);
  localparam int XFER_BYTES = SURFACES * SECTORS_PER_CLUSTER * SECTOR_BYTES;
  localparam int CNT_W      = $clog2(XFER_BYTES + 1);
  localparam logic [1:0] OFS_ADDR = 2'd0, OFS_CMD = 2'd1, OFS_STAT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER} state_t;

  state_t             state;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   count;
  logic               done;
  logic               busy;
  logic               beat;
  logic               last_byte;
  logic               start_ok;
  logic [REG_W-1:0]   status;

  assign busy       = (state != S_IDLE);
  assign bus_req    = busy;
  assign disk_ready = (state == S_XFER) && bus_gnt;
  assign beat       = disk_ready && disk_valid;
  assign mem_we     = beat;
  assign mem_addr   = addr_q;
  assign mem_wdata  = disk_data;
  assign last_byte  = beat && (count == CNT_W'(XFER_BYTES - 1));
  assign start_ok   = reg_wr && (reg_addr == OFS_CMD) && reg_wdata[0] && !reg_wdata[1]
                      && (state == S_IDLE);
  assign status     = {{(REG_W-CNT_W-2){1'b0}}, count, done, busy};

  always_comb begin
    case (reg_addr)
      OFS_ADDR: reg_rdata = REG_W'(addr_q);
      OFS_STAT: reg_rdata = status;
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      count  <= '0;
      done   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_ok) begin
            state <= S_REQ;
            done  <= 1'b0;
            count <= '0;
          end else if (reg_wr && reg_addr == OFS_ADDR) begin
            addr_q <= ADDR_W'(reg_wdata);
          end
        end
        S_REQ: if (bus_gnt) state <= S_XFER;
        S_XFER: begin
          if (beat) begin
            addr_q <= addr_q + ADDR_W'(1);
            count  <= count + CNT_W'(1);
          end
          if (last_byte) begin
            state <= S_IDLE;
            done  <= 1'b1;
            irq   <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_write_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bus_gnt && bus_req));
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_we) |=> (addr_q == $past(addr_q)));
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(XFER_BYTES));
  a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> (irq && done));
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r8_irq_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && count == CNT_W'(XFER_BYTES)));
endmodule

// File: tb/tb_cyl_dma_engine.sv
module tb_cyl_dma_engine;
  localparam int NBYTES = 6144;
  localparam logic [31:0] DONE_STAT = (32'(NBYTES) << 2) | 32'h2;
  // {start address, valid mask, data seed, grant delay}
  localparam logic [55:0] VEC [3] = '{
    {32'h0000_1000, 8'hFF,        8'h00, 8'd0},
    {32'hA200_4000, 8'b1010_1101, 8'h5A, 8'd5},
    {32'hFFFF_F000, 8'b0000_0001, 8'hC3, 8'd2}
  };

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        disk_valid = 0, disk_ready;
  logic [7:0]  disk_data = 0;
  logic        bus_req, bus_gnt = 0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        irq;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  cyl_dma_engine dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .disk_valid(disk_valid),
    .disk_data(disk_data), .disk_ready(disk_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic run_transfer(input logic [31:0] a, input logic [7:0] mask,
                              input logic [7:0] seed, input int gdelay);
    logic [31:0] v;
    int sent = 0, cyc = 0, bad_data = 0, bad_req = 0, bad_cnt = 0, early = 0;
    host_wr(2'd0, a);
    host_wr(2'd1, 32'h1);
    host_rd(2'd2, v); chk("R4 status after start", v, 32'h1);
    chk("R4 bus_req after start", 32'(bus_req), 32'h1);
    disk_valid = 1;
    for (int k = 0; k < gdelay; k++) begin
      @(negedge clk); #1;
      if (mem_we || disk_ready) early++;
    end
    chk("R4 no write before grant", 32'(early), 0);
    @(negedge clk); bus_gnt = 1;
    while (sent < NBYTES && cyc < 100000) begin
      @(negedge clk);
      disk_valid = mask[cyc % 8];
      disk_data  = seed + sent[7:0];
      reg_addr   = 2'd2;
      #1;
      if (!bus_req) bad_req++;
      if (reg_rdata[14:2] != sent[12:0]) bad_cnt++;
      if (disk_valid && disk_ready) begin
        if (!mem_we || mem_addr !== a + 32'(sent) || mem_wdata !== disk_data) bad_data++;
        sent++;
      end else if (mem_we) bad_data++;
      cyc++;
    end
    @(negedge clk); disk_valid = 0; #1;
    chk("R7 bus_req released", 32'(bus_req), 0);
    chk("R8 irq raised", 32'(irq), 1);
    host_rd(2'd2, v); chk("R8 final status", v, DONE_STAT);
    host_rd(2'd0, v); chk("R5 final address", v, a + 32'(NBYTES));
    @(negedge clk); #1;
    chk("R8 irq one cycle", 32'(irq), 0);
    chk("R5 address/data sequence", 32'(bad_data), 0);
    chk("R7 bus held through burst", 32'(bad_req), 0);
    chk("R6 count tracks bytes", 32'(bad_cnt), 0);
    chk("R6 bytes moved", 32'(sent), 32'(NBYTES));
    bus_gnt = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    disk_valid = 1;
    host_rd(2'd2, v); chk("R1 status reset", v, 0);
    host_rd(2'd0, v); chk("R1 address reset", v, 0);
    chk("R1 outputs idle", {29'd0, bus_req, irq, mem_we}, 0);
    disk_valid = 0;

    host_wr(2'd1, 32'h2);
    host_rd(2'd1, v); chk("R2 command reads zero", v, 0);
    host_rd(2'd3, v); chk("R2 offset 3 reads zero", v, 0);
    host_wr(2'd0, 32'h1234_5678);
    host_rd(2'd0, v); chk("R2 address readback", v, 32'h1234_5678);
    host_wr(2'd1, 32'h3);
    host_rd(2'd2, v); chk("R10 memory-to-disk not accepted", v, 0);
    chk("R10 no bus request", 32'(bus_req), 0);

    for (int i = 0; i < 3; i++)
      run_transfer(VEC[i][55:24], VEC[i][23:16], VEC[i][15:8], int'(VEC[i][7:0]));

    host_wr(2'd2, 32'hFFFF_FFFF);
    host_rd(2'd2, v); chk("R3 status write ignored", v, DONE_STAT);
    host_wr(2'd1, 32'h3);
    host_rd(2'd2, v); chk("R10 done kept after rejected command", v, DONE_STAT);

    host_wr(2'd0, 32'h0000_0100);
    host_wr(2'd1, 32'h1);
    host_wr(2'd0, 32'hDEAD_BEEF);
    host_rd(2'd0, v); chk("R9 address write ignored while busy", v, 32'h0000_0100);
    host_wr(2'd1, 32'h1);
    host_rd(2'd2, v); chk("R9 restart ignored while waiting", v, 32'h1);
    chk("R9 bus_req kept", 32'(bus_req), 1);
    bus_gnt = 1; disk_valid = 1;
    repeat (50) @(negedge clk);
    host_wr(2'd1, 32'h1);
    w = 0;
    while (!irq && w < 10000) begin @(negedge clk); #1; w++; end
    disk_valid = 0;
    chk("R9 completion reached", 32'(irq), 1);
    host_rd(2'd0, v); chk("R9 mid-burst restart ignored", v, 32'h0000_0100 + 32'(NBYTES));
    bus_gnt = 0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule